// File: doc/BRIEF.md
# I/O Translation Fault Register Bank

This block is the software-visible register bank of an I/O address translation unit. It holds a control word loaded from a version input, a fault status word, a fault address word, a set of per-slot bus configuration words, an arbiter enable word and a mask identification word. Software reaches all of them through one 32-bit, word-only read/write port. Reads return data one cycle after the access is accepted.

A separate translation path reports failed translations on a one-cycle fault strobe. The strobe carries the faulting page address and a flag that tells whether the failing access was a read. The bank records the fault in the status and address words and raises a level interrupt. Any read or write of either fault word lowers the interrupt again. Several words shape what is written to them. The fault status word always has its reserved bit set. The arbiter enable word keeps only its enable field and a fixed identity bit. The mask identification word only ever gains bits.

Top module: `iofault_regbank`

## Requirements
- R1: After reset, reads return the version input for the control word at offset 0x0000, 0x00800000 for fault status at 0x1000, 0 for fault address at 0x1004, 0 for each slot word at 0x1010 + 4*n, 0x00000008 for arbiter enable at 0x2000 and 0x23000000 for mask ID at 0x3018. The interrupt is low.
- R2: A write to the control, fault address or slot words stores all 32 bits. A read accepted on one clock edge shows that word on the read data output after that edge.
- R3: A write to fault status stores the written value ANDed with 0xFF0FFFFF, with bit 23 then set. Bit 23 of fault status is 1 in every cycle.
- R4: A fault strobe loads fault status with bits 31, 30, 23 and 17 set, plus bit 18 when the failing access was a read. It loads the fault address with the page address, and the interrupt is high after that edge.
- R5: An accepted read or write of the fault status or fault address word lowers the interrupt after that edge, unless a fault strobe arrives in the same cycle. In that case the fault wins, both for the interrupt and for the fault words.
- R6: A write to arbiter enable stores bits 20:16 of the written value with bit 3 forced to 1. Every other bit reads as 0.
- R7: A write to mask ID ORs bits 23:0 of the written value into the word. Bits are never cleared, and bits 31:24 of the written value have no effect.
- R8: A fault that arrives while fault status bit 31 is already set also sets bit 19 (multiple errors), and the newer page address replaces the older one.
- R9: Accesses to offsets outside the map, or with address bits 1:0 nonzero, read as zero and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| version_i | input | 32 | Value loaded into the control word at reset |
| acc_sel_i | input | 1 | Register access valid this cycle |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | ADDR_W | Byte offset of the accessed word |
| acc_wdata_i | input | 32 | Write data |
| acc_rdata_o | output | 32 | Read data, registered, valid after the accepting edge |
| flt_valid_i | input | 1 | Translation fault strobe |
| flt_page_i | input | 32 | Faulting page address |
| flt_is_read_i | input | 1 | Failing access was a read |
| irq_o | output | 1 | Level fault interrupt |

## Verification
Several invariants are checked by assertions in every cycle. Fault status bit 23 is always set. The arbiter enable word has only its enable field and bit 3 populated. The mask ID word never loses a bit. A fault strobe is always followed by a high interrupt, and a fault-word access without a fault is followed by a low one. The interrupt never rises without a fault. The exact stored values can only be shown by the bench's scenarios, which read them back through the port. These include the masked write results, the fault status encoding for read and write faults, the multiple-error bit on a second fault, fault priority over a simultaneous status write, and the silence of unmapped offsets.

// File: rtl/iof_pkg.sv
package iof_pkg;
  localparam int DW = 32;

  // register index assignment inside the bank
  localparam int IX_CTRL   = 0;
  localparam int IX_STAT   = 1;
  localparam int IX_FADDR  = 2;
  localparam int IX_ARB    = 3;
  localparam int IX_MASK   = 4;
  localparam int IX_SLOT0  = 5;

  // byte offsets
  localparam logic [15:0] OFF_CTRL  = 16'h0000;
  localparam logic [15:0] OFF_STAT  = 16'h1000;
  localparam logic [15:0] OFF_FADDR = 16'h1004;
  localparam logic [15:0] OFF_SLOT0 = 16'h1010;
  localparam logic [15:0] OFF_ARB   = 16'h2000;
  localparam logic [15:0] OFF_MASK  = 16'h3018;

  // fault status fields
  localparam logic [DW-1:0] ST_ERR   = 32'h8000_0000;
  localparam logic [DW-1:0] ST_LATE  = 32'h4000_0000;
  localparam logic [DW-1:0] ST_RSVD  = 32'h0080_0000;
  localparam logic [DW-1:0] ST_MULTI = 32'h0008_0000;
  localparam logic [DW-1:0] ST_RD    = 32'h0004_0000;
  localparam logic [DW-1:0] ST_AVAL  = 32'h0002_0000;
  localparam logic [DW-1:0] ST_WMASK = 32'hFF0F_FFFF;

  // arbiter enable and mask ID
  localparam logic [DW-1:0] ARB_KEEP  = 32'h001F_0000;
  localparam logic [DW-1:0] ARB_FIXED = 32'h0000_0008;
  localparam logic [DW-1:0] MASK_WIN  = 32'h00FF_FFFF;
  localparam logic [DW-1:0] MASK_RST  = 32'h2300_0000;
endpackage

// File: rtl/iof_decode.sv
module iof_decode
  import iof_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int NSLOT  = 4,
  localparam int NREG  = IX_SLOT0 + NSLOT
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   hit
);
  logic [15:0] a16;
  logic        aligned;

  assign a16     = 16'(addr);
  assign aligned = (addr[1:0] == 2'b00);

  assign hit[IX_CTRL]  = aligned && (a16 == OFF_CTRL);
  assign hit[IX_STAT]  = aligned && (a16 == OFF_STAT);
  assign hit[IX_FADDR] = aligned && (a16 == OFF_FADDR);
  assign hit[IX_ARB]   = aligned && (a16 == OFF_ARB);
  assign hit[IX_MASK]  = aligned && (a16 == OFF_MASK);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot_dec
    assign hit[IX_SLOT0+s] = aligned && (a16 == OFF_SLOT0 + 16'(4*s));
  end
endmodule

// File: rtl/iof_fault_capture.sv
module iof_fault_capture
  import iof_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stat,
  input  logic          wr_faddr,
  input  logic          touch,
  input  logic [DW-1:0] wdata,
  input  logic          flt_valid,
  input  logic [DW-1:0] flt_page,
  input  logic          flt_is_read,
  output logic [DW-1:0] stat_q,
  output logic [DW-1:0] faddr_q,
  output logic          irq_q
);
  logic [DW-1:0] stat_d, faddr_d;
  logic          irq_d;
  logic [DW-1:0] flt_word;

  always_comb begin
    flt_word = ST_ERR | ST_LATE | ST_RSVD | ST_AVAL;
    if (flt_is_read)     flt_word = flt_word | ST_RD;
    if ((stat_q & ST_ERR) != '0) flt_word = flt_word | ST_MULTI;
  end

  always_comb begin
    stat_d  = stat_q;
    faddr_d = faddr_q;
    irq_d   = irq_q;
    if (flt_valid) begin
      stat_d  = flt_word;
      faddr_d = flt_page;
      irq_d   = 1'b1;
    end else begin
      if (wr_stat)  stat_d  = (wdata & ST_WMASK) | ST_RSVD;
      if (wr_faddr) faddr_d = wdata;
      if (touch)    irq_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= ST_RSVD;
      faddr_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      stat_q  <= stat_d;
      faddr_q <= faddr_d;
      irq_q   <= irq_d;
    end
  end
endmodule

// File: rtl/iof_cfg_regs.sv
module iof_cfg_regs
  import iof_pkg::*;
#(
  parameter int NSLOT = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DW-1:0]            version,
  input  logic                     wr_ctrl,
  input  logic                     wr_arb,
  input  logic                     wr_mask,
  input  logic [NSLOT-1:0]         wr_slot,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            ctrl_q,
  output logic [DW-1:0]            arb_q,
  output logic [DW-1:0]            mask_q,
  output logic [NSLOT-1:0][DW-1:0] slot_q
);
  logic [DW-1:0] ctrl_d, arb_d, mask_d;

  always_comb begin
    ctrl_d = wr_ctrl ? wdata : ctrl_q;
    arb_d  = wr_arb  ? ((wdata & ARB_KEEP) | ARB_FIXED) : arb_q;
    mask_d = wr_mask ? (mask_q | (wdata & MASK_WIN)) : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= version;
      arb_q  <= ARB_FIXED;
      mask_q <= MASK_RST;
    end else begin
      ctrl_q <= ctrl_d;
      arb_q  <= arb_d;
      mask_q <= mask_d;
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [DW-1:0] slot_d;
    assign slot_d = wr_slot[s] ? wdata : slot_q[s];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[s] <= '0;
      else        slot_q[s] <= slot_d;
    end
  end
endmodule

// File: rtl/iofault_regbank.sv
module iofault_regbank
  import iof_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int NSLOT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       version_i,
  input  logic              acc_sel_i,
  input  logic              acc_wr_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [31:0]       acc_wdata_i,
  output logic [31:0]       acc_rdata_o,
  input  logic              flt_valid_i,
  input  logic [31:0]       flt_page_i,
  input  logic              flt_is_read_i,
  output logic              irq_o
);
  localparam int NREG = IX_SLOT0 + NSLOT;

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  logic [NREG-1:0] hit, wr_hit;
  logic            rd_en, touch;

  iof_decode #(.ADDR_W(ADDR_W), .NSLOT(NSLOT)) u_dec (
    .addr (acc_addr_i),
    .hit  (hit)
  );

  assign wr_hit = hit & {NREG{acc_sel_i & acc_wr_i}};
  assign rd_en  = acc_sel_i & ~acc_wr_i;
  assign touch  = acc_sel_i & (hit[IX_STAT] | hit[IX_FADDR]);

  logic [DW-1:0]            stat_q, faddr_q, ctrl_q, arb_q, mask_q;
  logic [NSLOT-1:0][DW-1:0] slot_q;
  logic                     irq_q;

  iof_fault_capture u_flt (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_stat     (wr_hit[IX_STAT]),
    .wr_faddr    (wr_hit[IX_FADDR]),
    .touch       (touch),
    .wdata       (acc_wdata_i),
    .flt_valid   (flt_valid_i),
    .flt_page    (flt_page_i),
    .flt_is_read (flt_is_read_i),
    .stat_q      (stat_q),
    .faddr_q     (faddr_q),
    .irq_q       (irq_q)
  );

  iof_cfg_regs #(.NSLOT(NSLOT)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .version (version_i),
    .wr_ctrl (wr_hit[IX_CTRL]),
    .wr_arb  (wr_hit[IX_ARB]),
    .wr_mask (wr_hit[IX_MASK]),
    .wr_slot (wr_hit[IX_SLOT0 +: NSLOT]),
    .wdata   (acc_wdata_i),
    .ctrl_q  (ctrl_q),
    .arb_q   (arb_q),
    .mask_q  (mask_q),
    .slot_q  (slot_q)
  );

  // read mux
  logic [NREG-1:0][DW-1:0] rd_vec;
  logic [DW-1:0]           rd_mux, rdata_d, rdata_q;

  always_comb begin
    rd_vec[IX_CTRL]  = ctrl_q;
    rd_vec[IX_STAT]  = stat_q;
    rd_vec[IX_FADDR] = faddr_q;
    rd_vec[IX_ARB]   = arb_q;
    rd_vec[IX_MASK]  = mask_q;
    for (int s = 0; s < NSLOT; s++) rd_vec[IX_SLOT0+s] = slot_q[s];
    rd_mux = '0;
    for (int r = 0; r < NREG; r++) rd_mux = rd_mux | (rd_vec[r] & {DW{hit[r]}});
    rdata_d = rd_en ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else             rdata_q <= rdata_d;
  end

  assign acc_rdata_o = rdata_q;
  assign irq_o       = irq_q;
endmodule

// File: rtl/iofault_regbank_chk.sv
module iofault_regbank_chk (
  input logic        clk,
  input logic        rst_ok,
  input logic        flt_valid,
  input logic        touch,
  input logic        irq,
  input logic [31:0] stat,
  input logic [31:0] arb,
  input logic [31:0] mask
);
  AST_RESV_BIT_SET: assert property (@(posedge clk) disable iff (!rst_ok)
    stat[23] == 1'b1); // R3
  AST_FAULT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_ok)
    flt_valid |=> irq); // R4
  AST_IRQ_ONLY_FROM_FAULT: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(irq) |-> $past(flt_valid)); // R4
  AST_ACCESS_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_ok)
    (touch && !flt_valid) |=> !irq); // R5
  AST_ARB_SHAPE: assert property (@(posedge clk) disable iff (!rst_ok)
    (arb[3] == 1'b1) && ((arb & 32'hFFE0_FFF7) == 32'h0)); // R6
  AST_MASK_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_ok)
    (mask & $past(mask)) == $past(mask)); // R7
endmodule

bind iofault_regbank iofault_regbank_chk u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .flt_valid (flt_valid_i),
  .touch     (touch),
  .irq       (irq_o),
  .stat      (stat_q),
  .arb       (arb_q),
  .mask      (mask_q)
);

// File: tb/iofault_regbank_test.sv
module iofault_regbank_test;
  localparam int ADDR_W = 14;
  localparam logic [31:0] VERSION = 32'h4100_0000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              acc_sel, acc_wr;
  logic [ADDR_W-1:0] acc_addr;
  logic [31:0]       acc_wdata, acc_rdata;
  logic              flt_valid, flt_is_read;
  logic [31:0]       flt_page;
  logic              irq;

  always #2.5 clk = ~clk;

  iofault_regbank #(.ADDR_W(ADDR_W), .NSLOT(4)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .version_i     (VERSION),
    .acc_sel_i     (acc_sel),
    .acc_wr_i      (acc_wr),
    .acc_addr_i    (acc_addr),
    .acc_wdata_i   (acc_wdata),
    .acc_rdata_o   (acc_rdata),
    .flt_valid_i   (flt_valid),
    .flt_page_i    (flt_page),
    .flt_is_read_i (flt_is_read),
    .irq_o         (irq)
  );

  int n_total = 0;
  int n_fail  = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        chk_due = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: a read accepted at an edge is compared at the next falling edge
  always @(posedge clk) chk_due <= acc_sel && !acc_wr;
  always @(negedge clk) begin
    if (chk_due) begin
      if (exp_q.size() == 0) check(1'b0, "scoreboard underflow", acc_rdata, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(acc_rdata === e, t, acc_rdata, e);
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    acc_sel = 1'b1; acc_wr = 1'b1; acc_addr = ADDR_W'(a); acc_wdata = d;
    @(negedge clk);
    acc_sel = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    acc_sel = 1'b1; acc_wr = 1'b0; acc_addr = ADDR_W'(a);
    @(negedge clk);
    acc_sel = 1'b0;
  endtask

  task automatic fault(input logic [31:0] page, input logic is_rd);
    @(negedge clk);
    flt_valid = 1'b1; flt_page = page; flt_is_read = is_rd;
    @(negedge clk);
    flt_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 32'h0, 32'h1);
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    rst_n = 1'b0; acc_sel = 1'b0; acc_wr = 1'b0; acc_addr = '0; acc_wdata = '0;
    flt_valid = 1'b0; flt_page = '0; flt_is_read = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    check(irq === 1'b0, "R1 irq after reset", {31'h0, irq}, 32'h0);
    rd(16'h0000, VERSION,      "R1 ctrl reset");
    rd(16'h1000, 32'h0080_0000, "R1 status reset");
    rd(16'h1004, 32'h0,        "R1 fault addr reset");
    rd(16'h1018, 32'h0,        "R1 slot2 reset");
    rd(16'h2000, 32'h0000_0008, "R1 arbiter reset");
    rd(16'h3018, 32'h2300_0000, "R1 mask id reset");

    // R2 full-width stores
    wr(16'h0000, 32'h1234_5678);
    wr(16'h1018, 32'hA5A5_5A5A);
    wr(16'h101C, 32'h0F0F_F0F0);
    wr(16'h1004, 32'hCAFE_F00D);
    rd(16'h0000, 32'h1234_5678, "R2 ctrl store");
    rd(16'h1018, 32'hA5A5_5A5A, "R2 slot2 store");
    rd(16'h101C, 32'h0F0F_F0F0, "R2 slot3 store");
    rd(16'h1010, 32'h0,         "R2 slot0 untouched");
    rd(16'h1004, 32'hCAFE_F00D, "R2 fault addr store");

    // R3 status write mask
    wr(16'h1000, 32'hFFFF_FFFF);
    rd(16'h1000, 32'hFF8F_FFFF, "R3 status all ones");
    wr(16'h1000, 32'h0);
    rd(16'h1000, 32'h0080_0000, "R3 status zero keeps bit 23");

    // R6 arbiter mask
    wr(16'h2000, 32'hFFFF_FFFF);
    rd(16'h2000, 32'h001F_0008, "R6 arbiter all ones");
    wr(16'h2000, 32'h0);
    rd(16'h2000, 32'h0000_0008, "R6 arbiter zero");

    // R7 mask id accumulation
    wr(16'h3018, 32'h0000_0F0F);
    rd(16'h3018, 32'h2300_0F0F, "R7 mask first OR");
    wr(16'h3018, 32'h00F0_00F0);
    rd(16'h3018, 32'h23F0_0FFF, "R7 mask second OR");
    wr(16'h3018, 32'h0);
    wr(16'h3018, 32'hFF00_0000);
    rd(16'h3018, 32'h23F0_0FFF, "R7 mask zero and high bits ignored");

    // R4 write fault on a clean status
    fault(32'h0004_2000, 1'b0);
    check(irq === 1'b1, "R4 irq after fault", {31'h0, irq}, 32'h1);
    rd(16'h1000, 32'hC082_0000, "R4 status write fault");
    check(irq === 1'b0, "R5 irq cleared by status read", {31'h0, irq}, 32'h0);
    rd(16'h1004, 32'h0004_2000, "R4 fault addr");

    // R8 second fault, read access, error already set
    fault(32'h0009_9000, 1'b1);
    check(irq === 1'b1, "R4 irq after second fault", {31'h0, irq}, 32'h1);
    rd(16'h1004, 32'h0009_9000, "R8 newer page address");
    check(irq === 1'b0, "R5 irq cleared by addr read", {31'h0, irq}, 32'h0);
    rd(16'h1000, 32'hC08E_0000, "R8 status multiple error");

    // R5 write of fault address clears irq
    fault(32'h0000_5000, 1'b0);
    check(irq === 1'b1, "R4 irq before addr write", {31'h0, irq}, 32'h1);
    wr(16'h1004, 32'h0);
    check(irq === 1'b0, "R5 irq cleared by addr write", {31'h0, irq}, 32'h0);
    wr(16'h1000, 32'h0);

    // R5 fault wins over a simultaneous status write
    @(negedge clk);
    acc_sel = 1'b1; acc_wr = 1'b1; acc_addr = ADDR_W'(16'h1000); acc_wdata = 32'h0;
    flt_valid = 1'b1; flt_page = 32'h0001_1000; flt_is_read = 1'b0;
    @(negedge clk);
    acc_sel = 1'b0; acc_wr = 1'b0; flt_valid = 1'b0;
    check(irq === 1'b1, "R5 fault beats clear", {31'h0, irq}, 32'h1);
    rd(16'h1000, 32'hC082_0000, "R5 fault beats status write");
    rd(16'h1004, 32'h0001_1000, "R5 fault addr on collision");

    // R9 unmapped and misaligned accesses
    wr(16'h0800, 32'hDEAD_BEEF);
    wr(16'h0002, 32'hBEEF_0000);
    rd(16'h0800, 32'h0, "R9 unmapped read");
    rd(16'h3FFC, 32'h0, "R9 top offset read");
    rd(16'h0001, 32'h0, "R9 misaligned read");
    rd(16'h0000, 32'h1234_5678, "R9 ctrl untouched by ignored writes");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 32'h0);
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule